// File: doc/BRIEF.md
# Supply Voltage Detector Control Register

This block is the software-facing control point for an external supply voltage comparator. One 4-bit register turns the detector on and off and selects the comparison threshold. The block drives the comparator's enable line and threshold select, and it freezes the comparator's low-supply output into a read-only result bit. The freeze happens at the moment software turns the detector off.

The comparator needs a settling period before its output can be trusted. The block therefore counts the clock cycles the detector stays on. When the detector is switched off, it records whether that on-time reached the equivalent of the minimum settling period (100 µs by default). The record is a sticky flag that software or neighbouring logic can use to reject a result taken too early. The enable line follows the on/off bit exactly, so the comparator draws current only while software asks for it.

Top module: `vdet_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0, `det_en` is 0, `det_sel` is 0 and `res_valid` is 0.
- R2: A write (`wr_en` = 1) stores `wr_data[0]` into the on bit, which reads back at `rd_data[0]` from the next cycle. `det_en` equals the on bit in every cycle.
- R3: A write stores `wr_data[3:2]` into the threshold field, which reads back at `rd_data[3:2]` and drives `det_sel` from the next cycle. The encoding is 0 = 2.6 V, 1 = 2.5 V, 2 = 2.4 V, 3 = 2.3 V. Without a write the field holds.
- R4: Bit 1 is read-only. The value written to `wr_data[1]` has no effect on `rd_data[1]`.
- R5: A write that clears the on bit while it is 1 loads `det_low`, sampled at that clock edge, into `rd_data[1]` from the next cycle. A value of 1 means the supply is low and 0 means it is normal.
- R6: `rd_data[1]` changes only on a 1-to-0 change of the on bit. A clearing write while the detector is already off, or any write that leaves the bit set, leaves it unchanged.
- R7: If the clearing write comes N cycles after the write that set the on bit, and N >= MIN_CYCLES (CLK_HZ/1e6 × MIN_ON_US, which is 5000 by default), then `res_valid` is 1 from the next cycle.
- R8: If N < MIN_CYCLES, the same clearing write makes `res_valid` 0. At all other times `res_valid` holds its value, including while the detector is on.
- R9: Writing 1 to the on bit while it is already 1 does not restart the on-time count.
- R10: The threshold may be rewritten while the detector is on. `det_sel` carries the newest value up to and including the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data: [0] on, [1] ignored, [3:2] threshold |
| rd_data | output | 4 | Read data: [0] on, [1] result, [3:2] threshold |
| det_en | output | 1 | Comparator enable |
| det_sel | output | 2 | Comparator threshold select |
| det_low | input | 1 | Comparator low-supply output |
| res_valid | output | 1 | Last result met the minimum on-time |

## Verification
A wrong capture or hold in the result register shows on `rd_data[1]` one cycle after a clearing write, or as drift during idle cycles. A miscounted on-time shows only on `res_valid`, and only at the next off edge. For that reason the bench places off edges exactly one cycle on either side of MIN_CYCLES, and it also issues a repeated set write that must not restart the count. Threshold and enable errors show one cycle after the write that causes them.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
    localparam int REG_W      = 4;
    localparam int BIT_ON     = 0;
    localparam int BIT_RES    = 1;
    localparam int BIT_SEL_LO = 2;
    localparam int SEL_W      = 2;

    typedef enum logic [SEL_W-1:0] {
        TH_2V6 = 2'd0,
        TH_2V5 = 2'd1,
        TH_2V4 = 2'd2,
        TH_2V3 = 2'd3
    } thresh_e;

    typedef struct packed {
        logic    on;
        thresh_e sel;
    } ctrl_s;
endpackage

// File: rtl/vdet_regs.sv
module vdet_regs
    import vdet_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic               on_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic               rise_o,
    output logic               fall_o
);
    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (wr_en) begin
            ctrl_d.on  = wr_data[BIT_ON];
            ctrl_d.sel = thresh_e'(wr_data[BIT_SEL_LO +: SEL_W]);
            rise_o     = wr_data[BIT_ON] & ~ctrl_q.on;
            fall_o     = ~wr_data[BIT_ON] & ctrl_q.on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{on: 1'b0, sel: TH_2V6};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign on_o  = ctrl_q.on;
    assign sel_o = ctrl_q.sel;
endmodule

// File: rtl/vdet_dwell.sv
module vdet_dwell #(
    parameter int MIN_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic valid_o
);
    localparam int CNT_W = $clog2(MIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } dwell_s;

    dwell_s st_d, st_q;
    logic   at_max;

    assign at_max = (st_q.cnt >= CNT_MAX);

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.cnt = CNT_W'(1);
        end else if (fall_i) begin
            st_d.valid = at_max;
        end else if (on_i && !at_max) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
endmodule

// File: rtl/vdet_capture.sv
module vdet_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic low_i,
    output logic res_o
);
    logic res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (fall_i) res_d = low_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= 1'b0;
        else        res_q <= res_d;
    end

    assign res_o = res_q;
endmodule

// File: rtl/vdet_ctrl.sv
module vdet_ctrl
    import vdet_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int MIN_ON_US = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_data,
    output logic [3:0]       rd_data,
    output logic             det_en,
    output logic [1:0]       det_sel,
    input  logic             det_low,
    output logic             res_valid
);
    localparam int MIN_CYCLES = (CLK_HZ / 1_000_000) * MIN_ON_US;

    logic             on_w, rise_w, fall_w, res_w;
    logic [SEL_W-1:0] sel_w;

    vdet_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .on_o    (on_w),
        .sel_o   (sel_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    vdet_dwell #(.MIN_CYCLES(MIN_CYCLES)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_i    (on_w),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .valid_o (res_valid)
    );

    vdet_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall_w),
        .low_i  (det_low),
        .res_o  (res_w)
    );

    always_comb begin
        rd_data                         = '0;
        rd_data[BIT_ON]                 = on_w;
        rd_data[BIT_RES]                = res_w;
        rd_data[BIT_SEL_LO +: SEL_W]    = sel_w;
    end

    assign det_en  = on_w;
    assign det_sel = sel_w;
endmodule

// File: rtl/vdet_ctrl_chk.sv
module vdet_ctrl_chk #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int MIN_ON_US = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_data,
    input logic [3:0] rd_data,
    input logic       det_en,
    input logic [1:0] det_sel,
    input logic       det_low,
    input logic       res_valid
);
    localparam int MIN_CYCLES = (CLK_HZ / 1_000_000) * MIN_ON_US;

    logic fall, rise;
    int   on_cnt;

    assign fall = wr_en && !wr_data[0] && rd_data[0];
    assign rise = wr_en && wr_data[0] && !rd_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              on_cnt <= 0;
        else if (rise)                           on_cnt <= 1;
        else if (rd_data[0] && on_cnt < MIN_CYCLES) on_cnt <= on_cnt + 1;
    end

    p_onbit_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[0] == $past(wr_data[0]));
    p_en_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        det_en == rd_data[0]);
    p_sel_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[3:2] == $past(wr_data[3:2])) && (det_sel == $past(wr_data[3:2])));
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(det_sel));
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> rd_data[1] == $past(det_low));
    p_res_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(rd_data[1]));
    p_valid_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && on_cnt >= MIN_CYCLES) |=> res_valid);
    p_valid_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && on_cnt < MIN_CYCLES) |=> !res_valid);
    p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(res_valid));
endmodule

bind vdet_ctrl vdet_ctrl_chk #(.CLK_HZ(CLK_HZ), .MIN_ON_US(MIN_ON_US)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .det_en    (det_en),
    .det_sel   (det_sel),
    .det_low   (det_low),
    .res_valid (res_valid)
);

// File: tb/test_vdet_ctrl.sv
module test_vdet_ctrl;
    localparam int MIN = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic       det_low = 1'b0;
    logic [3:0] rd_data;
    logic       det_en;
    logic [1:0] det_sel;
    logic       res_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // expected item: {det_sel, det_en, res_valid, rd_data}
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // specification model
    logic       m_on = 0, m_res = 0, m_valid = 0;
    logic [1:0] m_sel = 0;
    int         m_since = 0;

    always #10 clk = ~clk;

    vdet_ctrl i_vdet_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .det_en(det_en), .det_sel(det_sel),
        .det_low(det_low), .res_valid(res_valid)
    );

    function automatic logic [7:0] expected();
        return {m_sel, m_on, m_valid, m_sel, m_res, m_on};
    endfunction

    function automatic void model_tick(logic we, logic [3:0] d, logic low);
        if (m_on) m_since++;
        if (we) begin
            if (d[0] && !m_on) m_since = 0;
            if (!d[0] && m_on) begin
                m_res   = low;
                m_valid = (m_since >= MIN);
            end
            m_on  = d[0];
            m_sel = d[3:2];
        end
    endfunction

    task automatic wr(input logic [3:0] d, input logic low, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; det_low = low;
        @(posedge clk);
        model_tick(1'b1, d, low);
        exp_q.push_back(expected());
        tag_q.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // idle cycles; the first one is the negedge left by wr
    task automatic idle(input int n, input logic low);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            wr_en = 1'b0; det_low = low;
            @(posedge clk);
            model_tick(1'b0, 4'h0, low);
        end
    endtask

    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            logic [7:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {det_sel, det_en, res_valid, rd_data};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: got sel=%0d en=%0b valid=%0b rd=%b, expected sel=%0d en=%0b valid=%0b rd=%b",
                         t, a[7:6], a[5], a[4], a[3:0], e[7:6], e[5], e[4], e[3:0]);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if ({det_sel, det_en, res_valid, rd_data} !== 8'h00) begin
            n_fail++;
            $display("FAIL R1 reset: got %b expected %b", {det_sel, det_en, res_valid, rd_data}, 8'h00);
        end
        rst_n = 1'b1;

        // R2 R3 R4: on, threshold 3 (2.3 V), bit1 written as 1 is ignored
        wr(4'b1111, 1'b0, "R2/R3/R4 set on with sel 3");
        idle(10, 1'b1);
        // R5 R8: early clear captures low supply, result untrusted
        wr(4'b0110, 1'b1, "R5/R8 short capture");
        // R6: clear while off, comparator now normal, result must hold
        wr(4'b0000, 1'b0, "R6 clear while off");
        wr(4'b1010, 1'b0, "R4 bit1 written 1 while off");
        // R7: long on-time, normal supply
        wr(4'b0001, 1'b0, "R2 set on sel 0");
        idle(6000, 1'b1);
        wr(4'b0000, 1'b0, "R7 long capture");
        // R8 boundary: N = MIN-1
        wr(4'b0101, 1'b0, "R3 set on sel 1");
        idle(MIN - 2, 1'b0);
        wr(4'b0100, 1'b1, "R8 off at MIN-1");
        // R7 boundary: N = MIN
        wr(4'b1001, 1'b1, "R3 set on sel 2");
        idle(MIN - 1, 1'b1);
        wr(4'b1000, 1'b0, "R7 off at exactly MIN");
        // R9: rewrite 1 mid-way must not restart count
        wr(4'b0001, 1'b0, "R9 set on");
        idle(3000, 1'b0);
        wr(4'b0001, 1'b0, "R9 rewrite on");
        idle(MIN - 3002, 1'b0);
        wr(4'b0000, 1'b1, "R9 off at MIN after rewrite");
        // R10: threshold changes while on
        wr(4'b0001, 1'b0, "R10 set on sel 0");
        wr(4'b1001, 1'b0, "R10 sel 2 while on");
        wr(4'b1101, 1'b0, "R10 sel 3 while on");
        wr(4'b1100, 1'b1, "R10 off keeps sel 3");
        idle(2, 1'b0);
        n_checks++;
        if (det_sel !== 2'd3 || det_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 after capture: got sel=%0d en=%0b expected sel=3 en=0", det_sel, det_en);
        end
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule